// File: doc/BRIEF.md
# Tag Check Fault Policy Unit

This block sits behind a memory tag comparator and decides what happens once a mismatch has been found. Each fault strobe arrives with the faulting virtual address, the access direction, a description of the translation regime (user-level or not, one or two address ranges, the regime's own exception level), the current exception level and the system control word that governs the regime. From a two-bit reporting mode taken out of that control word, the unit either raises a synchronous abort request or records the fault in a sticky per-level asynchronous status register.

The abort request is a single-cycle pulse. The captured address and syndrome stay on the outputs until the exception logic acknowledges them. Each of the four asynchronous status registers holds one bit per address range. Those bits are only cleared by software, which overwrites a whole register through a write port. A strobe that arrives while reporting is disabled is flagged as an error and changes nothing else.

Top module: `tfp_policy_unit`

## Requirements
- R1: After reset, abort_req, abort_pend and mode_err are 0 and every async_stat bit is 0.
- R2: The reporting mode is sys_ctl[39:38] when rgm_user is 1 and sys_ctl[41:40] otherwise. The field that is not selected has no effect.
- R3: Mode 1 produces abort_req on the cycle after the strobe, with abort_addr equal to flt_addr and abort_syn = {cur_el != 0, flt_write, 6'h11}, where bit 7 is the privileged flag, bit 6 is write-not-read and bits 5:0 are the fault status code. The status registers do not change.
- R4: Mode 2 sets a status bit and raises no abort.
- R5: Mode 3 handles a write as in mode 2 and a read as in mode 1.
- R6: An asynchronous fault updates register 0 (async_stat[1:0]) for a user-level regime, and register rgm_el (async_stat[2*rgm_el+1 : 2*rgm_el]) otherwise. Exactly one bit is set per fault.
- R7: Within the chosen register, the bit set is flt_addr[55] when rgm_two_rng is 1, and bit 0 otherwise.
- R8: Status bits are sticky: a later fault ORs into a register and never clears a bit.
- R9: When sw_we is 1, register sw_el is replaced with sw_wdata on the next edge. An asynchronous set to that register in the same cycle is still applied on top of the written value.
- R10: abort_req is high for exactly one cycle. After it, abort_pend stays 1 and abort_addr/abort_syn stay unchanged until a cycle with abort_ack = 1. That cycle clears abort_pend.
- R11: A synchronous fault that arrives while abort_pend is 1 and abort_ack is 0 is dropped and leaves the captured values untouched. A fault in the same cycle as abort_ack is accepted.
- R12: A strobe in mode 0 raises mode_err for one cycle and raises no abort and no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_vld | input | 1 | Tag mismatch strobe |
| flt_addr | input | 64 | Faulting virtual address |
| flt_write | input | 1 | 1 for a write access, 0 for a read |
| rgm_user | input | 1 | Regime is a user-level regime |
| rgm_two_rng | input | 1 | Regime has two address ranges |
| rgm_el | input | 2 | Exception level that owns the regime |
| cur_el | input | 2 | Current exception level |
| sys_ctl | input | 64 | System control word of the regime |
| abort_ack | input | 1 | Exception logic has taken the abort |
| sw_we | input | 1 | Software write to a status register |
| sw_el | input | 2 | Status register selected for the write |
| sw_wdata | input | 2 | Value written |
| abort_req | output | 1 | One-cycle synchronous abort request |
| abort_pend | output | 1 | Captured abort awaiting acknowledge |
| abort_addr | output | 64 | Captured faulting address |
| abort_syn | output | 8 | Captured syndrome |
| mode_err | output | 1 | Strobe arrived with reporting disabled |
| async_stat | output | 8 | Status registers, level e in bits 2e+1:2e |

## Verification
The main sweep covers every combination of regime kind, range count, regime level, current level, mode, direction and address bit 55. The field that is not selected always holds the complement of the selected one, so a wrong field choice shows up as a wrong action. Because the expected status vector is one-hot, a wrong register or wrong range bit is caught separately from a wrong action, and the syndrome pins down both the direction bit and the privilege bit. Directed sequences then cover the pending window: faults that are dropped while an abort is held, a fault accepted in the acknowledge cycle, accumulation across faults, and a software write colliding with a set to the same register.

// File: rtl/tfp_pkg.sv
package tfp_pkg;

  localparam int unsigned FSC_W   = 6;
  localparam logic [FSC_W-1:0] FSC_TAG = 6'h11;
  localparam int unsigned RNG_W   = 2;

  typedef enum logic [1:0] {
    RPT_OFF   = 2'd0,
    RPT_SYNC  = 2'd1,
    RPT_ASYNC = 2'd2,
    RPT_SPLIT = 2'd3
  } rpt_mode_e;

  typedef struct packed {
    logic             priv;
    logic             wnr;
    logic [FSC_W-1:0] fsc;
  } abort_syn_t;

  localparam int unsigned SYN_W = $bits(abort_syn_t);

endpackage

// File: rtl/tfp_rst_sync.sv
module tfp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_q_n <= stage_q;
    end
  end
endmodule

// File: rtl/tfp_decode.sv
module tfp_decode
  import tfp_pkg::*;
#(
  parameter int unsigned CTL_W         = 64,
  parameter int unsigned NUM_EL        = 4,
  parameter int unsigned USER_MODE_LSB = 38,
  parameter int unsigned PRIV_MODE_LSB = 40,
  localparam int unsigned EL_W         = $clog2(NUM_EL)
) (
  input  logic                    flt_vld,
  input  logic                    flt_write,
  input  logic                    addr_sel,
  input  logic                    rgm_user,
  input  logic                    rgm_two_rng,
  input  logic [EL_W-1:0]         rgm_el,
  input  logic [CTL_W-1:0]        sys_ctl,
  output logic                    take_sync,
  output logic                    bad_strobe,
  output logic [NUM_EL*RNG_W-1:0] set_mask
);
  rpt_mode_e       mode;
  logic            go_async;
  logic [EL_W-1:0] tgt_el;
  logic            rng_bit;

  always_comb begin
    if (rgm_user) mode = rpt_mode_e'(sys_ctl[USER_MODE_LSB +: 2]);
    else          mode = rpt_mode_e'(sys_ctl[PRIV_MODE_LSB +: 2]);
  end

  always_comb begin
    take_sync  = 1'b0;
    go_async   = 1'b0;
    bad_strobe = 1'b0;
    if (flt_vld) begin
      unique case (mode)
        RPT_OFF:   bad_strobe = 1'b1;
        RPT_SYNC:  take_sync  = 1'b1;
        RPT_ASYNC: go_async   = 1'b1;
        RPT_SPLIT: begin
          if (flt_write) go_async  = 1'b1;
          else           take_sync = 1'b1;
        end
        default:   bad_strobe = 1'b1;
      endcase
    end
  end

  assign tgt_el  = rgm_user ? '0 : rgm_el;
  assign rng_bit = rgm_two_rng & addr_sel;

  for (genvar e = 0; e < NUM_EL; e++) begin : g_mask
    always_comb begin
      set_mask[e*RNG_W +: RNG_W] = '0;
      if (go_async && (tgt_el == EL_W'(e))) begin
        set_mask[e*RNG_W + 32'(rng_bit)] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tfp_stat_bank.sv
module tfp_stat_bank
  import tfp_pkg::*;
#(
  parameter int unsigned NUM_EL = 4,
  localparam int unsigned EL_W  = $clog2(NUM_EL)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_EL*RNG_W-1:0] set_mask,
  input  logic                    sw_we,
  input  logic [EL_W-1:0]         sw_el,
  input  logic [RNG_W-1:0]        sw_wdata,
  output logic [NUM_EL*RNG_W-1:0] stat_q
);
  for (genvar e = 0; e < NUM_EL; e++) begin : g_reg
    logic             wr_hit;
    logic             en;
    logic [RNG_W-1:0] set_e;
    logic [RNG_W-1:0] d;
    logic [RNG_W-1:0] q;

    assign set_e  = set_mask[e*RNG_W +: RNG_W];
    assign wr_hit = sw_we && (sw_el == EL_W'(e));
    assign en     = wr_hit || (|set_e);

    always_comb begin
      d = (wr_hit ? sw_wdata : q) | set_e;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign stat_q[e*RNG_W +: RNG_W] = q;
  end
endmodule

// File: rtl/tfp_abort_hold.sv
module tfp_abort_hold
  import tfp_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] addr,
  input  abort_syn_t        syn,
  input  logic              ack,
  output logic              req_q,
  output logic              pend_q,
  output logic [ADDR_W-1:0] addr_q,
  output abort_syn_t        syn_q
);
  logic pend_keep;
  logic accept;
  logic req_d;
  logic pend_d;

  always_comb begin
    pend_keep = pend_q && !ack;
    accept    = take && !pend_keep;
    req_d     = accept;
    pend_d    = accept || pend_keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      syn_q  <= '0;
    end else if (accept) begin
      addr_q <= addr;
      syn_q  <= syn;
    end
  end
endmodule

// File: rtl/tfp_policy_unit.sv
module tfp_policy_unit
  import tfp_pkg::*;
#(
  parameter int unsigned ADDR_W        = 64,
  parameter int unsigned CTL_W         = 64,
  parameter int unsigned NUM_EL        = 4,
  parameter int unsigned SEL_BIT       = 55,
  parameter int unsigned USER_MODE_LSB = 38,
  parameter int unsigned PRIV_MODE_LSB = 40,
  localparam int unsigned EL_W         = $clog2(NUM_EL),
  localparam int unsigned STAT_W       = NUM_EL * RNG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt_vld,
  input  logic [ADDR_W-1:0] flt_addr,
  input  logic              flt_write,
  input  logic              rgm_user,
  input  logic              rgm_two_rng,
  input  logic [EL_W-1:0]   rgm_el,
  input  logic [EL_W-1:0]   cur_el,
  input  logic [CTL_W-1:0]  sys_ctl,
  input  logic              abort_ack,
  input  logic              sw_we,
  input  logic [EL_W-1:0]   sw_el,
  input  logic [RNG_W-1:0]  sw_wdata,
  output logic              abort_req,
  output logic              abort_pend,
  output logic [ADDR_W-1:0] abort_addr,
  output logic [SYN_W-1:0]  abort_syn,
  output logic              mode_err,
  output logic [STAT_W-1:0] async_stat
);
  logic              rst_q_n;
  logic              take_sync;
  logic              bad_strobe;
  logic [STAT_W-1:0] set_mask;
  abort_syn_t        syn_new;
  abort_syn_t        syn_held;
  logic              err_q;

  tfp_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  tfp_decode #(
    .CTL_W         (CTL_W),
    .NUM_EL        (NUM_EL),
    .USER_MODE_LSB (USER_MODE_LSB),
    .PRIV_MODE_LSB (PRIV_MODE_LSB)
  ) u_dec (
    .flt_vld     (flt_vld),
    .flt_write   (flt_write),
    .addr_sel    (flt_addr[SEL_BIT]),
    .rgm_user    (rgm_user),
    .rgm_two_rng (rgm_two_rng),
    .rgm_el      (rgm_el),
    .sys_ctl     (sys_ctl),
    .take_sync   (take_sync),
    .bad_strobe  (bad_strobe),
    .set_mask    (set_mask)
  );

  always_comb begin
    syn_new.priv = (cur_el != '0);
    syn_new.wnr  = flt_write;
    syn_new.fsc  = FSC_TAG;
  end

  tfp_abort_hold #(.ADDR_W(ADDR_W)) u_abort (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .take   (take_sync),
    .addr   (flt_addr),
    .syn    (syn_new),
    .ack    (abort_ack),
    .req_q  (abort_req),
    .pend_q (abort_pend),
    .addr_q (abort_addr),
    .syn_q  (syn_held)
  );

  tfp_stat_bank #(.NUM_EL(NUM_EL)) u_stat (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .set_mask (set_mask),
    .sw_we    (sw_we),
    .sw_el    (sw_el),
    .sw_wdata (sw_wdata),
    .stat_q   (async_stat)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) err_q <= 1'b0;
    else          err_q <= bad_strobe;
  end

  assign abort_syn = syn_held;
  assign mode_err  = err_q;
endmodule

// File: rtl/tfp_policy_chk.sv
module tfp_policy_chk #(
  parameter int unsigned ADDR_W        = 64,
  parameter int unsigned CTL_W         = 64,
  parameter int unsigned NUM_EL        = 4,
  parameter int unsigned USER_MODE_LSB = 38,
  parameter int unsigned PRIV_MODE_LSB = 40,
  localparam int unsigned STAT_W       = NUM_EL * 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flt_vld,
  input logic [ADDR_W-1:0] flt_addr,
  input logic              rgm_user,
  input logic [CTL_W-1:0]  sys_ctl,
  input logic              abort_ack,
  input logic              sw_we,
  input logic              abort_req,
  input logic              abort_pend,
  input logic [ADDR_W-1:0] abort_addr,
  input logic [7:0]        abort_syn,
  input logic              mode_err,
  input logic [STAT_W-1:0] async_stat
);
  logic [1:0] mode_w;
  assign mode_w = rgm_user ? sys_ctl[USER_MODE_LSB +: 2] : sys_ctl[PRIV_MODE_LSB +: 2];

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_req && !abort_ack) |=> !abort_req); // R10

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pend && !abort_ack) |=> (abort_pend && $stable(abort_addr) && $stable(abort_syn))); // R11

  AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_vld && mode_w == 2'd1 && !(abort_pend && !abort_ack)) |=> (abort_req && abort_addr == $past(flt_addr))); // R3

  AST_ASYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_vld && mode_w == 2'd2) |=> !abort_req); // R4

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_we |=> ((async_stat & $past(async_stat)) == $past(async_stat))); // R8

  AST_ONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_we |=> ($countones(async_stat ^ $past(async_stat)) <= 1)); // R6

  AST_MODE0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_vld && mode_w == 2'd0 && !sw_we) |=> (mode_err && !abort_req && $stable(async_stat))); // R12
endmodule

bind tfp_policy_unit tfp_policy_chk #(
  .ADDR_W        (ADDR_W),
  .CTL_W         (CTL_W),
  .NUM_EL        (NUM_EL),
  .USER_MODE_LSB (USER_MODE_LSB),
  .PRIV_MODE_LSB (PRIV_MODE_LSB)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .flt_vld    (flt_vld),
  .flt_addr   (flt_addr),
  .rgm_user   (rgm_user),
  .sys_ctl    (sys_ctl),
  .abort_ack  (abort_ack),
  .sw_we      (sw_we),
  .abort_req  (abort_req),
  .abort_pend (abort_pend),
  .abort_addr (abort_addr),
  .abort_syn  (abort_syn),
  .mode_err   (mode_err),
  .async_stat (async_stat)
);

// File: tb/tfp_policy_unit_test.sv
module tfp_policy_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flt_vld, flt_write, rgm_user, rgm_two_rng;
  logic [63:0] flt_addr, sys_ctl;
  logic [1:0]  rgm_el, cur_el, sw_el, sw_wdata;
  logic        abort_ack, sw_we;
  logic        abort_req, abort_pend, mode_err;
  logic [63:0] abort_addr;
  logic [7:0]  abort_syn;
  logic [7:0]  async_stat;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tfp_policy_unit uut (
    .clk(clk), .rst_n(rst_n), .flt_vld(flt_vld), .flt_addr(flt_addr),
    .flt_write(flt_write), .rgm_user(rgm_user), .rgm_two_rng(rgm_two_rng),
    .rgm_el(rgm_el), .cur_el(cur_el), .sys_ctl(sys_ctl), .abort_ack(abort_ack),
    .sw_we(sw_we), .sw_el(sw_el), .sw_wdata(sw_wdata), .abort_req(abort_req),
    .abort_pend(abort_pend), .abort_addr(abort_addr), .abort_syn(abort_syn),
    .mode_err(mode_err), .async_stat(async_stat)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_all();
    for (int e = 0; e < 4; e++) begin
      sw_we = 1'b1; sw_el = 2'(e); sw_wdata = 2'b00;
      tick();
    end
    sw_we = 1'b0;
    abort_ack = 1'b1;
    tick();
    abort_ack = 1'b0;
  endtask

  function automatic logic [63:0] make_ctl(input bit user, input logic [1:0] m);
    logic [63:0] c;
    c = 64'hC3A5_0000_F0F0_1234;
    c[39:38] = user ? m : ~m;
    c[41:40] = user ? ~m : m;
    return c;
  endfunction

  task automatic fault(input bit user, input bit two, input logic [1:0] rel,
                       input logic [1:0] cel, input logic [1:0] m, input bit wr,
                       input logic [63:0] a);
    rgm_user = user; rgm_two_rng = two; rgm_el = rel; cur_el = cel;
    sys_ctl = make_ctl(user, m); flt_write = wr; flt_addr = a; flt_vld = 1'b1;
    tick();
    flt_vld = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; flt_vld = 0; flt_write = 0; rgm_user = 0; rgm_two_rng = 0;
    flt_addr = '0; sys_ctl = '0; rgm_el = 0; cur_el = 0; abort_ack = 0;
    sw_we = 0; sw_el = 0; sw_wdata = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    chk(!abort_req && !abort_pend && !mode_err, "R1 ctrl", {61'd0, abort_req, abort_pend, mode_err}, 64'd0);
    chk(async_stat == 8'd0, "R1 stat", 64'(async_stat), 64'd0);

    // Sweep: R2 R3 R4 R5 R6 R7 R12
    for (int u = 0; u < 2; u++)
    for (int t = 0; t < 2; t++)
    for (int re = 0; re < 4; re++)
    for (int ce = 0; ce < 4; ce++)
    for (int m = 0; m < 4; m++)
    for (int w = 0; w < 2; w++)
    for (int b = 0; b < 2; b++) begin
      logic [63:0] a;
      bit exp_sync, exp_async, exp_err;
      logic [7:0] exp_stat, exp_syn;
      int tgt, sel;
      clear_all();
      a = 64'h0123_4567_89AB_CDE0 ^ 64'(((u*2+t)*16+re*4+ce)*256 + m*16 + w*8);
      a[55] = 1'(b);
      fault(1'(u), 1'(t), 2'(re), 2'(ce), 2'(m), 1'(w), a);
      exp_err   = (m == 0);
      exp_sync  = (m == 1) || (m == 3 && w == 0);
      exp_async = (m == 2) || (m == 3 && w == 1);
      tgt = u ? 0 : re;
      sel = t ? b : 0;
      exp_stat = exp_async ? 8'(1 << (tgt*2 + sel)) : 8'd0;
      exp_syn  = {(ce != 0), 1'(w), 6'h11};
      chk(abort_req == exp_sync, "R2/R3/R5 abort_req", 64'(abort_req), 64'(exp_sync));
      chk(async_stat == exp_stat, "R4/R6/R7 async_stat", 64'(async_stat), 64'(exp_stat));
      chk(mode_err == exp_err, "R12 mode_err", 64'(mode_err), 64'(exp_err));
      if (exp_sync) begin
        chk(abort_addr == a, "R3 abort_addr", abort_addr, a);
        chk(abort_syn == exp_syn, "R3 abort_syn", 64'(abort_syn), 64'(exp_syn));
      end
    end

    // R10 / R11 pending window
    clear_all();
    fault(1'b0, 1'b0, 2'd1, 2'd1, 2'd1, 1'b0, 64'hAAAA_0000_0000_1000);
    chk(abort_req && abort_pend, "R10 pulse start", {62'd0, abort_req, abort_pend}, 64'd3);
    tick();
    chk(!abort_req && abort_pend, "R10 pulse one cycle", {62'd0, abort_req, abort_pend}, 64'd1);
    chk(abort_addr == 64'hAAAA_0000_0000_1000, "R10 addr held", abort_addr, 64'hAAAA_0000_0000_1000);
    fault(1'b0, 1'b0, 2'd1, 2'd0, 2'd1, 1'b1, 64'hBBBB_0000_0000_2000);
    chk(!abort_req, "R11 dropped no pulse", 64'(abort_req), 64'd0);
    chk(abort_addr == 64'hAAAA_0000_0000_1000, "R11 addr kept", abort_addr, 64'hAAAA_0000_0000_1000);
    chk(abort_syn == 8'h91, "R11 syn kept", 64'(abort_syn), 64'h91);
    abort_ack = 1'b1;
    fault(1'b0, 1'b0, 2'd1, 2'd0, 2'd1, 1'b1, 64'hCCCC_0000_0000_3000);
    abort_ack = 1'b0;
    chk(abort_req && abort_addr == 64'hCCCC_0000_0000_3000, "R11 accepted with ack", abort_addr, 64'hCCCC_0000_0000_3000);
    chk(abort_syn == 8'h51, "R11 new syn", 64'(abort_syn), 64'h51);
    abort_ack = 1'b1; tick(); abort_ack = 1'b0;
    chk(!abort_pend && !abort_req, "R10 ack clears", {62'd0, abort_req, abort_pend}, 64'd0);

    // R8 sticky accumulation
    clear_all();
    fault(1'b0, 1'b1, 2'd2, 2'd2, 2'd2, 1'b0, 64'h0080_0000_0000_0000);
    fault(1'b0, 1'b1, 2'd2, 2'd2, 2'd2, 1'b1, 64'h0000_0000_0000_0040);
    fault(1'b1, 1'b0, 2'd3, 2'd0, 2'd3, 1'b1, 64'h0080_0000_0000_0000);
    chk(async_stat == 8'b0011_0001, "R8 sticky accumulate", 64'(async_stat), 64'h31);
    fault(1'b0, 1'b1, 2'd2, 2'd2, 2'd1, 1'b1, 64'h0080_0000_0000_0000);
    chk(async_stat == 8'b0011_0001, "R8 sync leaves stat", 64'(async_stat), 64'h31);

    // R9 software write collision and replace
    sw_we = 1'b1; sw_el = 2'd2; sw_wdata = 2'b00;
    fault(1'b0, 1'b1, 2'd2, 2'd2, 2'd2, 1'b0, 64'h0080_0000_0000_0000);
    sw_we = 1'b0;
    chk(async_stat == 8'b0010_0001, "R9 write with set", 64'(async_stat), 64'h21);
    sw_we = 1'b1; sw_el = 2'd3; sw_wdata = 2'b01; tick();
    sw_we = 1'b0;
    chk(async_stat == 8'b0110_0001, "R9 replace", 64'(async_stat), 64'h61);
    sw_we = 1'b1; sw_el = 2'd0; sw_wdata = 2'b00; tick();
    sw_we = 1'b0;
    chk(async_stat == 8'b0110_0000, "R9 clear level 0", 64'(async_stat), 64'h60);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule